// File: doc/BRIEF.md
# Interrupt Active Priority Tracker

This block records which preemption levels have an interrupt that is active and not yet priority-dropped. It holds a bank of up to four 32-bit words, one bit per preemption level. A set bit means at least one interrupt at that level is active and undropped. A clear bit means none is active at that level, or every active one has been dropped. The preemption depth is fixed by a parameter at 5, 6 or 7 bits, which gives 32, 64 or 128 levels held in one, two or four words.

An activate strobe comes with an 8-bit priority and marks the matching level. A drop strobe clears the most urgent marked level, which is the one with the lowest number. The block always shows the running priority, meaning the most urgent marked level converted back to 8-bit priority form. Software can read or replace any word through a port that is indexed by a 2-bit word number. The word appears in the low half of a 64-bit value whose upper half is always zero. An access to a word that does not exist under the configured depth raises an undefined-access flag.

Top module: `active_prio_tracker`

## Requirements
- R1: While and after reset, every level bit is 0 and run_prio reads 8'hFF.
- R2: With depth PB, a priority maps to level L = prio[7:8-PB]. The level lives in word L[PB-1:5] at bit L[4:0]. For PB=6 that is word prio[7], bit prio[6:2]; for PB=7 it is word prio[7:6], bit prio[5:1]; for PB=5 it is word 0, bit prio[7:3].
- R3: An act_valid strobe sets the mapped level bit, visible from the next cycle. All other bits are unchanged.
- R4: A drop_valid strobe clears the lowest-numbered set bit across the whole bank from the next cycle. If no bit is set, the strobe has no effect.
- R5: When activate and drop arrive in the same cycle, the drop target is chosen from the current state and the activate bit is then set. If both hit the same level, that level stays set.
- R6: run_prio equals the lowest set level shifted left by 8-PB, or 8'hFF when no bit is set. It follows the stored state combinationally.
- R7: A read returns the indexed word in sw_rdata[31:0] in the same cycle. sw_rdata[63:32] is always zero.
- R8: A write stores sw_wdata[31:0] into the indexed word from the next cycle. sw_wdata[63:32] is discarded.
- R9: A write has priority over a same-cycle activate or drop that targets the same word. Activate and drop targets in other words still take effect.
- R10: Words with index 1<<(PB-5) or above do not exist. A read or write to one raises sw_undef in the same cycle. A read of such a word returns 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset that clears the bank |
| act_valid | input | 1 | Activate strobe |
| act_prio | input | 8 | Priority of the activated interrupt |
| drop_valid | input | 1 | Priority-drop strobe |
| sw_rd_en | input | 1 | Software read enable |
| sw_wr_en | input | 1 | Software write enable |
| sw_idx | input | 2 | Word index for read or write |
| sw_wdata | input | 64 | Write data; only bits 31:0 are kept |
| sw_rdata | output | 64 | Read data, upper half zero |
| sw_undef | output | 1 | Access targets a word that does not exist |
| run_prio | output | 8 | Running priority, 8'hFF when idle |

## Verification
The assertions assume that every strobe is a clean, single-cycle level sampled at the clock edge. The drop-count property only applies when no write or activate competes in the same cycle, so it is guarded on those inputs being low. The missing-word property assumes that a write to a missing word is not paired with an activate or drop. The stimulus drives one kind of event per cycle for the sweeps and the drop sequences. Overlapping events appear only in dedicated cycles, and the bench predicts those from the stated precedence. A missing-word write is always issued on its own.

// File: rtl/aptrk_pkg.sv
package aptrk_pkg;
  localparam int PRIO_W    = 8;
  localparam int WORD_W    = 32;
  localparam int REG_W     = 64;
  localparam int MAX_WORDS = 4;
  localparam int IDX_W     = 2;

  // level number of a priority for a given preemption depth
  function automatic int unsigned prio_level(input logic [PRIO_W-1:0] p,
                                             input int unsigned pb);
    return int'(p) >> (PRIO_W - pb);
  endfunction

  // priority value of a level for a given preemption depth
  function automatic logic [PRIO_W-1:0] level_prio(input int unsigned lvl,
                                                   input int unsigned pb);
    return PRIO_W'(lvl << (PRIO_W - pb));
  endfunction

  // number of words present for a given preemption depth
  function automatic int unsigned words_for(input int unsigned pb);
    return 1 << (pb - 5);
  endfunction
endpackage

// File: rtl/aptrk_level_map.sv
module aptrk_level_map
  import aptrk_pkg::*;
#(
  parameter int PB     = 6,
  parameter int LEVELS = 1 << PB,
  parameter int LW     = PB
) (
  input  logic [PRIO_W-1:0] prio,
  output logic [LW-1:0]     level,
  output logic [LEVELS-1:0] mask
);
  always_comb begin
    level = LW'(prio_level(prio, PB));
    mask  = '0;
    mask[level] = 1'b1;
  end
endmodule

// File: rtl/aptrk_lowest_find.sv
module aptrk_lowest_find #(
  parameter int N  = 64,
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vec,
  output logic [LW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |vec;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = LW'(i);
    end
  end

  // R6
  found_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> vec[idx]);
  // R6
  none_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any |-> ($countones(vec) == 0));
endmodule

// File: rtl/aptrk_word.sv
module aptrk_word #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb begin
    if (wr_hit) q_next = wdata;
    else        q_next = (q & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  // R8
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (q == $past(wdata)));
  // R3
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> (($past(set_mask) & ~q) == '0));
  // R4
  clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && set_mask == '0) |=> ((q & $past(clr_mask)) == '0));
endmodule

// File: rtl/active_prio_tracker.sv
module active_prio_tracker
  import aptrk_pkg::*;
#(
  parameter int PB = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_valid,
  input  logic [7:0]        act_prio,
  input  logic              drop_valid,
  input  logic              sw_rd_en,
  input  logic              sw_wr_en,
  input  logic [1:0]        sw_idx,
  input  logic [63:0]       sw_wdata,
  output logic [63:0]       sw_rdata,
  output logic              sw_undef,
  output logic [7:0]        run_prio
);
  localparam int NW     = words_for(PB);
  localparam int LEVELS = NW * WORD_W;
  localparam int LW     = $clog2(LEVELS);
  localparam logic [PRIO_W-1:0] LOW_MASK = PRIO_W'((1 << (PRIO_W - PB)) - 1);

  logic [LW-1:0]     act_level;
  logic [LEVELS-1:0] act_mask;
  logic [LEVELS-1:0] set_flat;
  logic [LEVELS-1:0] clr_flat;
  logic [LEVELS-1:0] bank_flat;
  logic [LW-1:0]     low_idx;
  logic              low_any;
  logic              idx_missing;
  logic [WORD_W-1:0] rd_words [MAX_WORDS];
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^sw_wdata[REG_W-1:WORD_W];

  aptrk_level_map #(.PB(PB), .LEVELS(LEVELS), .LW(LW)) map_i (
    .prio  (act_prio),
    .level (act_level),
    .mask  (act_mask)
  );

  aptrk_lowest_find #(.N(LEVELS), .LW(LW)) find_i (
    .clk   (clk),
    .rst_n (rst_n),
    .vec   (bank_flat),
    .idx   (low_idx),
    .any   (low_any)
  );

  assign set_flat = act_valid ? act_mask : '0;

  always_comb begin
    clr_flat = '0;
    if (drop_valid && low_any) clr_flat[low_idx] = 1'b1;
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic              wr_hit;
    logic [WORD_W-1:0] q;
    assign wr_hit = sw_wr_en && (sw_idx == IDX_W'(w));
    aptrk_word #(.W(WORD_W)) word_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (wr_hit),
      .wdata    (sw_wdata[WORD_W-1:0]),
      .set_mask (set_flat[w*WORD_W +: WORD_W]),
      .clr_mask (clr_flat[w*WORD_W +: WORD_W]),
      .q        (q)
    );
    assign bank_flat[w*WORD_W +: WORD_W] = q;
  end

  for (genvar w = 0; w < MAX_WORDS; w++) begin : g_rd
    if (w < NW) begin : g_have
      assign rd_words[w] = bank_flat[w*WORD_W +: WORD_W];
    end else begin : g_none
      assign rd_words[w] = '0;
    end
  end

  assign idx_missing = (int'(sw_idx) >= NW);
  assign sw_undef    = (sw_rd_en || sw_wr_en) && idx_missing;
  assign sw_rdata    = {{(REG_W-WORD_W){1'b0}}, rd_words[sw_idx]};
  assign run_prio    = low_any ? level_prio(int'(low_idx), PB) : 8'hFF;

  // R10
  undef_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_undef |-> (sw_rd_en || sw_wr_en));
  // R10
  missing_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en && sw_undef && !act_valid && !drop_valid) |=> $stable(bank_flat));
  // R4
  drop_removes_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_valid && !act_valid && !sw_wr_en && low_any)
      |=> ($countones(bank_flat) == $past($countones(bank_flat)) - 1));
  // R4
  drop_empty_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_valid && !act_valid && !sw_wr_en && !low_any) |=> (bank_flat == '0));
  // R6
  run_prio_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_prio != 8'hFF) |-> ((run_prio & LOW_MASK) == '0));
  // R7
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rdata[REG_W-1:WORD_W] == '0);
endmodule

// File: tb/active_prio_tracker_tb_top.sv
`timescale 1ns/1ps
module active_prio_tracker_tb_top;
  localparam int PB     = 6;
  localparam int NW     = 1 << (PB - 5);
  localparam int LEVELS = NW * 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        act_valid, drop_valid, sw_rd_en, sw_wr_en;
  logic [7:0]  act_prio;
  logic [1:0]  sw_idx;
  logic [63:0] sw_wdata;
  logic [63:0] sw_rdata;
  logic        sw_undef;
  logic [7:0]  run_prio;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [LEVELS-1:0] exp_bits;

  always #2 clk = ~clk;

  active_prio_tracker #(.PB(PB)) dut_i (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_prio(act_prio),
    .drop_valid(drop_valid), .sw_rd_en(sw_rd_en), .sw_wr_en(sw_wr_en),
    .sw_idx(sw_idx), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .sw_undef(sw_undef), .run_prio(run_prio)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_run();
    for (int i = 0; i < LEVELS; i++)
      if (exp_bits[i]) return 8'(i << (8 - PB));
    return 8'hFF;
  endfunction

  function automatic logic [63:0] exp_word(input int idx);
    if (idx >= NW) return 64'h0;
    return {32'h0, exp_bits[idx*32 +: 32]};
  endfunction

  // one cycle of stimulus, driven at negedge; model follows the requirements
  task automatic drive(input bit av, input logic [7:0] p, input bit dv,
                       input bit wv, input int widx, input logic [63:0] wd);
    logic [LEVELS-1:0] nxt;
    nxt = exp_bits;
    if (dv) begin
      for (int i = 0; i < LEVELS; i++)
        if (exp_bits[i]) begin nxt[i] = 1'b0; break; end
    end
    if (av) nxt[int'(p) >> (8 - PB)] = 1'b1;
    if (wv && widx < NW) nxt[widx*32 +: 32] = wd[31:0];
    act_valid = av; act_prio = p; drop_valid = dv;
    sw_wr_en = wv; sw_idx = 2'(widx); sw_wdata = wd;
    if (wv) begin
      #1;
      chk("R10 write undef flag", {63'h0, sw_undef}, {63'h0, widx >= NW});
    end
    @(negedge clk);
    act_valid = 0; drop_valid = 0; sw_wr_en = 0; sw_wdata = '0;
    exp_bits = nxt;
  endtask

  task automatic rd_chk(input int idx, input string req);
    sw_rd_en = 1; sw_idx = 2'(idx);
    #1;
    chk(req, sw_rdata, exp_word(idx));
    chk("R10 read undef flag", {63'h0, sw_undef}, {63'h0, idx >= NW});
    sw_rd_en = 0;
  endtask

  task automatic run_chk(input string req);
    chk(req, {56'h0, run_prio}, {56'h0, exp_run()});
  endtask

  task automatic rd_all(input string req);
    for (int k = 0; k < 4; k++) rd_chk(k, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0; act_valid = 0; act_prio = 0; drop_valid = 0;
    sw_rd_en = 0; sw_wr_en = 0; sw_idx = 0; sw_wdata = 0;
    exp_bits = '0;
    repeat (3) @(negedge clk);
    run_chk("R1 idle in reset");
    rst_n = 1;
    @(negedge clk);
    run_chk("R1 idle after reset");
    rd_all("R1 words clear after reset");

    // R2 R3 R6: every priority, activate alone then drop alone
    for (int p = 0; p < 256; p++) begin
      drive(1, 8'(p), 0, 0, 0, '0);
      run_chk("R6 running priority after activate");
      rd_chk(p >> 7, "R2 R3 mapped word and bit");
      drive(0, 0, 1, 0, 0, '0);
      run_chk("R4 R6 idle after drop");
      rd_chk(p >> 7, "R4 word clear after drop");
    end

    // R4: several levels, dropped in ascending level order, then empty drop
    drive(1, 8'd200, 0, 0, 0, '0);
    drive(1, 8'd8,   0, 0, 0, '0);
    drive(1, 8'd100, 0, 0, 0, '0);
    drive(1, 8'd64,  0, 0, 0, '0);
    drive(1, 8'd252, 0, 0, 0, '0);
    drive(1, 8'd9,   0, 0, 0, '0);
    run_chk("R6 lowest of many");
    rd_all("R3 many set");
    for (int k = 0; k < 7; k++) begin
      drive(0, 0, 1, 0, 0, '0);
      run_chk("R4 drop order");
      rd_all("R4 bank after drop");
    end

    // R5: activate and drop together
    drive(1, 8'd40, 0, 0, 0, '0);
    drive(1, 8'd40, 1, 0, 0, '0);
    run_chk("R5 same level stays set");
    rd_all("R5 same level");
    drive(1, 8'd20, 1, 0, 0, '0);
    run_chk("R5 drop old, set new");
    rd_all("R5 different level");

    // R7 R8: write word 1, upper bits discarded
    drive(0, 0, 0, 1, 1, 64'hDEAD_BEEF_1234_5678);
    rd_all("R7 R8 write word 1");
    run_chk("R6 after write");

    // R9: write wins over activate into the same word
    drive(1, 8'd0, 0, 1, 0, 64'h0000_0000_0000_0100);
    rd_all("R9 write beats activate same word");
    // R9: activate into the other word still applies
    drive(1, 8'h80, 0, 1, 0, 64'h0000_0000_0000_0000);
    rd_all("R9 activate other word applies");
    run_chk("R9 running priority");
    // R9: drop targeting the written word is lost
    drive(0, 0, 0, 1, 0, 64'h0000_0000_8000_0002);
    drive(0, 0, 1, 1, 0, 64'h0000_0000_0000_0006);
    rd_all("R9 write beats drop same word");

    // R10: write to missing words changes nothing
    drive(0, 0, 0, 1, 2, 64'hFFFF_FFFF_FFFF_FFFF);
    drive(0, 0, 0, 1, 3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_all("R10 missing write ignored");
    run_chk("R10 running priority unchanged");

    // R4: drop on an empty bank
    drive(0, 0, 0, 1, 0, '0);
    drive(0, 0, 0, 1, 1, '0);
    drive(0, 0, 1, 0, 0, '0);
    run_chk("R4 empty drop idle");
    rd_all("R4 empty drop no effect");

    // R1: reset mid-run clears state
    drive(1, 8'd33, 0, 0, 0, '0);
    rst_n = 0;
    @(negedge clk);
    exp_bits = '0;
    run_chk("R1 reset clears");
    rst_n = 1;
    @(negedge clk);
    rd_all("R1 words after second reset");

    finish_run();
  end
endmodule